// File: doc/BRIEF.md
# Shared Inductor Priority Arbiter

This block decides which of three power clients may use one shared inductor at a given moment. The clients are a step-down converter, a flip rectifier and a step-up converter. Each client signals that it wants the inductor with a rising edge on its request line. It gives the inductor back with a rising edge on its release line. The arbiter answers each client on a single acknowledge line, which stays high for as long as that client holds the inductor.

When the inductor is idle, a request is granted at the very next clock edge. When the inductor is in use, a new request edge is stored in a pending register. The stored requests are served by fixed priority once the current holder has released. The fixed order is step-down converter, then flip rectifier, then step-up converter.

A hold watchdog raises an error output when a single grant lasts longer than a parameterised number of cycles. This gives the system a way to detect that the bound on grant latency has been broken.

Top module: `coil_share_arbiter`

## Requirements
- R1: After reset, every bit of `ack_o` is 0 and `hold_err_o` is 0.
- R2: When no acknowledge is high, a rising edge on `req_i[k]` sets `ack_o[k]` at the same clock edge that samples that rising edge. The client index is bit 0 for the step-down converter, bit 1 for the flip rectifier and bit 2 for the step-up converter.
- R3: A rising request edge that arrives while another client holds the grant leaves `ack_o` unchanged.
- R4: A rising edge on `rel_i[k]` while `ack_o[k]` is high clears `ack_o[k]` at the edge that samples it. At the next edge, the lowest-index pending client is granted.
- R5: When rising request edges arrive together at an idle arbiter, the lowest index is granted first. The other clients stay pending and are then served in ascending index order.
- R6: At most one bit of `ack_o` is high in any cycle.
- R7: A release edge from a client that does not hold the grant has no effect on `ack_o`.
- R8: A request is an edge and not a level. If a client keeps `req_i` high across its own release, it is not granted again.
- R9: `hold_err_o` goes high once a single grant has been held for `HOLD_LIMIT` cycles. It goes low at the edge where that grant is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 3 | Request lines, edge-sensitive, one per client |
| rel_i | input | 3 | Release lines, edge-sensitive, one per client |
| ack_o | output | 3 | Grant acknowledge, at most one bit high |
| hold_err_o | output | 1 | Grant held for at least HOLD_LIMIT cycles |

## Verification
The bench queues two requests behind a low-priority holder. They arrive in reverse priority order, so a design that served them in arrival order, or granted while the inductor was busy, would show the wrong acknowledge or two acknowledges at once. A release pulse from a client that does not hold the grant is applied; a design that decoded releases without matching them to the owner would drop the grant. A request line is held high across its own release, which catches a design that treats requests as levels and re-grants the same client. The watchdog threshold is probed one cycle before and at the limit, which exposes a counter that is off by one.

// File: rtl/coil_arb_pkg.sv
package coil_arb_pkg;
  localparam int unsigned NUM_CLIENTS = 3;

  // index order is also priority order (lowest index wins)
  typedef enum logic [1:0] {
    CL_STEP_DOWN = 2'd0,
    CL_FLIP      = 2'd1,
    CL_STEP_UP   = 2'd2
  } client_e;

  typedef logic [NUM_CLIENTS-1:0] client_vec_t;
endpackage

// File: rtl/rise_detect.sv
module rise_detect #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o
);
  logic [W-1:0] lvl_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_q[i] <= 1'b0;
      else         lvl_q[i] <= lvl_i[i];
    end
    assign rise_o[i] = lvl_i[i] & ~lvl_q[i];
  end
endmodule

// File: rtl/fixed_prio_pick.sv
module fixed_prio_pick #(
  parameter int unsigned W = 3
) (
  input  logic [W-1:0] req_i,
  output logic [W-1:0] gnt_o
);
  logic [W:0] seen;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_chain
    assign seen[i+1] = seen[i] | req_i[i];
    assign gnt_o[i]  = req_i[i] & ~seen[i];
  end
endmodule

// File: rtl/hold_watchdog.sv
module hold_watchdog #(
  parameter int unsigned LIMIT = 800
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  output logic err_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!busy_i)      cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign err_o = busy_i && (cnt_q == LIM);

  assert_err_needs_holder_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> busy_i);
  assert_err_persists_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && busy_i) |=> (err_o || !busy_i));
endmodule

// File: rtl/coil_share_arbiter.sv
module coil_share_arbiter
  import coil_arb_pkg::*;
#(
  parameter int unsigned HOLD_LIMIT = 800
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_CLIENTS-1:0] req_i,
  input  logic [NUM_CLIENTS-1:0] rel_i,
  output logic [NUM_CLIENTS-1:0] ack_o,
  output logic                   hold_err_o
);
  client_vec_t req_rise, rel_rise, cand, pick, pend_q, ack_q;
  logic busy, rel_hit;

  rise_detect #(.W(NUM_CLIENTS)) i_req_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(req_i), .rise_o(req_rise)
  );
  rise_detect #(.W(NUM_CLIENTS)) i_rel_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(rel_i), .rise_o(rel_rise)
  );

  assign cand    = pend_q | req_rise;
  assign busy    = |ack_q;
  assign rel_hit = |(rel_rise & ack_q);  // only the holder can release

  fixed_prio_pick #(.W(NUM_CLIENTS)) i_pick (.req_i(cand), .gnt_o(pick));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q  <= '0;
      pend_q <= '0;
    end else if (!busy) begin
      ack_q  <= pick;
      pend_q <= cand & ~pick;
    end else begin
      pend_q <= cand;
      if (rel_hit) ack_q <= '0;  // next grant one edge later
    end
  end

  assign ack_o = ack_q;

  hold_watchdog #(.LIMIT(HOLD_LIMIT)) i_wdog (
    .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy), .err_o(hold_err_o)
  );

  assert_single_ack_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_o));
  assert_idle_grant_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && |cand) |=> busy);
  assert_prio_top_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && cand[CL_STEP_DOWN]) |=> ack_o[CL_STEP_DOWN]);
  assert_prio_mid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !cand[CL_STEP_DOWN] && cand[CL_FLIP]) |=> ack_o[CL_FLIP]);
  assert_busy_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !rel_hit) |=> $stable(ack_o));
  assert_release_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_hit |=> !busy);
  assert_foreign_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && |(rel_rise & ~ack_q) && !rel_hit) |=> $stable(ack_o));
endmodule

// File: tb/test_coil_share_arbiter.sv
`timescale 1ns/1ps
module test_coil_share_arbiter;
  localparam int unsigned LIM = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] req = '0;
  logic [2:0] rel = '0;
  logic [2:0] ack;
  logic       err;
  int vectors = 0;
  int misses  = 0;

  always #2.5 clk = ~clk;

  coil_share_arbiter #(.HOLD_LIMIT(LIM)) i_coil_share_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .rel_i(rel),
    .ack_o(ack), .hold_err_o(err)
  );

  task automatic check(input string tag, input logic [2:0] exp_ack, input logic exp_err);
    vectors++;
    if (ack !== exp_ack || err !== exp_err) begin
      misses++;
      $display("FAIL %s: ack=%b err=%b expected ack=%b err=%b", tag, ack, err, exp_ack, exp_err);
    end
    vectors++;
    if (!$onehot0(ack)) begin
      misses++;
      $display("FAIL R6: ack=%b expected at most one bit", ack);
    end
  endtask

  // one-cycle pulse; returns at the negedge after the sampling posedge
  task automatic pulse(input logic [2:0] r, input logic [2:0] l);
    req = req | r;
    rel = l;
    @(negedge clk);
    req = req & ~r;
    rel = '0;
  endtask

  task automatic t_reset();
    check("R1 reset", 3'b000, 1'b0);
  endtask

  task automatic t_free();
    pulse(3'b010, 3'b000); check("R2 idle grant flip", 3'b010, 1'b0);
    pulse(3'b000, 3'b010); check("R4 release clears", 3'b000, 1'b0);
    @(negedge clk);        check("R4 nothing pending", 3'b000, 1'b0);
  endtask

  task automatic t_queue();
    pulse(3'b100, 3'b000); check("R2 idle grant step-up", 3'b100, 1'b0);
    pulse(3'b010, 3'b000); check("R3 busy ignores flip req", 3'b100, 1'b0);
    pulse(3'b001, 3'b000); check("R3 busy ignores step-down req", 3'b100, 1'b0);
    pulse(3'b000, 3'b001); check("R7 foreign release", 3'b100, 1'b0);
    pulse(3'b000, 3'b010); check("R7 foreign release 2", 3'b100, 1'b0);
    pulse(3'b000, 3'b100); check("R4 holder release", 3'b000, 1'b0);
    @(negedge clk);        check("R4 priority step-down", 3'b001, 1'b0);
    pulse(3'b000, 3'b001); check("R4 release step-down", 3'b000, 1'b0);
    @(negedge clk);        check("R4 then flip", 3'b010, 1'b0);
    pulse(3'b000, 3'b010); check("R4 release flip", 3'b000, 1'b0);
    @(negedge clk);        check("R4 queue empty", 3'b000, 1'b0);
  endtask

  task automatic t_simul();
    pulse(3'b111, 3'b000); check("R5 simultaneous lowest wins", 3'b001, 1'b0);
    pulse(3'b000, 3'b001); check("R5 release 0", 3'b000, 1'b0);
    @(negedge clk);        check("R5 second flip", 3'b010, 1'b0);
    pulse(3'b000, 3'b010); check("R5 release 1", 3'b000, 1'b0);
    @(negedge clk);        check("R5 third step-up", 3'b100, 1'b0);
    pulse(3'b000, 3'b100); check("R5 release 2", 3'b000, 1'b0);
    @(negedge clk);        check("R5 drained", 3'b000, 1'b0);
  endtask

  task automatic t_level();
    req = 3'b001;
    @(negedge clk);        check("R8 level grant", 3'b001, 1'b0);
    @(negedge clk);        check("R8 level steady", 3'b001, 1'b0);
    rel = 3'b001;
    @(negedge clk);
    rel = '0;              check("R8 release", 3'b000, 1'b0);
    @(negedge clk);        check("R8 no regrant on level", 3'b000, 1'b0);
    @(negedge clk);        check("R8 still idle", 3'b000, 1'b0);
    req = '0;
    @(negedge clk);
  endtask

  task automatic t_wdog();
    pulse(3'b010, 3'b000); check("R9 grant", 3'b010, 1'b0);
    for (int i = 0; i < LIM - 1; i++) @(negedge clk);
    check("R9 below limit", 3'b010, 1'b0);
    @(negedge clk);        check("R9 at limit", 3'b010, 1'b1);
    @(negedge clk);        check("R9 stays", 3'b010, 1'b1);
    pulse(3'b000, 3'b010); check("R9 clears on release", 3'b000, 1'b0);
  endtask

  initial begin
    #(200000 * 5);
    misses++;
    $display("FAIL watchdog: ack=%b expected run to finish", ack);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_free();
    t_queue();
    t_simul();
    t_level();
    t_wdog();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule